// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether a destination MAC address belongs to one of the multicast groups a receiver has subscribed to. It keeps a 256-bin bit table, held as eight 32-bit words. To classify an address, it runs the Ethernet CRC-32 over the six address bytes, one byte per clock. An 8-bit bin number comes from the bit-reversed CRC. The filter reports a hit when that bin is set and the address carries the group flag.

Configuration logic writes whole table words or sets and clears single bins by bin number. It can read any word back at any time. The receive path starts a lookup with the 48-bit address and gets a one-cycle done pulse. The pulse comes with the hit flag and the computed bin number.

Top module: `mcast_hash_filter`

## Requirements
- R1: While reset is applied and in the first cycle after it, every table word reads zero, and `lk_done`, `lk_hit` and `lk_busy` are low.
- R2: A word write with `cfg_wr_en` high replaces word `cfg_wr_word` with `cfg_wr_data` on that clock edge. `cfg_rd_data` always shows word `cfg_rd_word` without delay.
- R3: A bin set (`bin_op_en` high, `bin_op_set` high) writes a one into a single bit. For bin b, that bit is bit position 31 - b[4:0] of word b[7:5], so bin 0 is bit 31 of word 0 and bin 255 is bit 0 of word 7. Every other table bit keeps its value.
- R4: A bin clear (`bin_op_en` high, `bin_op_set` low) writes a zero into the same bit position as R3 and leaves every other bit unchanged.
- R5: When a word write and a bin operation happen in the same cycle, the word write is applied first and the bin operation then modifies the result.
- R6: The bin number is formed in three steps. First, the CRC-32 runs with the reflected polynomial 0xEDB88320 and an initial value of all ones, least significant bit of each byte first, over byte `lk_mac[47:40]` first through `lk_mac[7:0]` last. Second, the CRC is complemented and bit-reversed. Third, the top 8 bits of the reversed value are the bin number, which is reported on `lk_bin`.
- R7: For an address whose group flag `lk_mac[40]` is one, `lk_hit` equals the table bit of the computed bin.
- R8: An address whose group flag `lk_mac[40]` is zero never produces a hit, whatever the table holds.
- R9: A start accepted on a clock edge gives exactly one `lk_done` pulse in the seventh cycle after that edge, one cycle after the sixth byte is folded in. `lk_busy` is high from the cycle after the start until the cycle in which `lk_done` is high.
- R10: A start raised while `lk_busy` is high is ignored. The running lookup finishes with its own result, and no extra done pulse follows.
- R11: A table change that lands on the same clock edge as the lookup result does not affect that result. It is seen by the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Whole-word table write enable |
| cfg_wr_word | input | 3 | Word number for the word write |
| cfg_wr_data | input | 32 | Word write data |
| bin_op_en | input | 1 | Single-bin operation enable |
| bin_op_set | input | 1 | 1 sets the bin, 0 clears it |
| bin_op_bin | input | 8 | Bin number for the bin operation |
| cfg_rd_word | input | 3 | Word number for read-back |
| cfg_rd_data | output | 32 | Contents of the selected word |
| lk_start | input | 1 | Start a lookup (taken when not busy) |
| lk_mac | input | 48 | Destination address, first byte in [47:40] |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle pulse: result valid |
| lk_hit | output | 1 | Address passes the group filter |
| lk_bin | output | 8 | Bin number computed for the address |

## Verification
A single-bit error in the table shows up as a wrong word on the read port in the cycle after the faulty update. It also shows up as a wrong hit on any lookup that lands in that bin. The bin set and clear sweeps therefore cover all 256 bins against a bench model. A corrupted CRC step, byte order or bit reversal shows up at once as a wrong `lk_bin` on the done pulse. A miscount in the byte sequencer moves the done pulse off its seventh cycle, so it is caught on the first lookup. A start that slips past `lk_busy`, or a table write that leaks into a result already under way, changes the reported bin or hit of that same lookup. It may also add a done pulse within the following eight cycles.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int MHF_WORDS     = 8;
    localparam int MHF_WORD_W    = 32;
    localparam int MHF_MAC_BYTES = 6;
    localparam int MHF_MAC_W     = 8 * MHF_MAC_BYTES;
    localparam int MHF_BIN_W     = $clog2(MHF_WORDS * MHF_WORD_W);
    localparam int MHF_SEL_W     = $clog2(MHF_WORDS);
    localparam int MHF_POS_W     = $clog2(MHF_WORD_W);

    localparam logic [31:0] MHF_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_RUN    = 2'd1,
        ENG_FINISH = 2'd2
    } eng_state_e;

    // finished CRC, handed from the engine to the result stage
    typedef struct packed {
        logic                 valid;
        logic                 group;
        logic [MHF_BIN_W-1:0] bin;
    } bin_req_t;

    // single-bin table update
    typedef struct packed {
        logic                 valid;
        logic                 set;
        logic [MHF_BIN_W-1:0] bin;
    } bin_op_t;

    // fold one byte into a reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_fold_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'h0, data};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ MHF_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

    // complement, bit-reverse, keep the top MHF_BIN_W bits
    function automatic logic [MHF_BIN_W-1:0] bin_from_crc(input logic [31:0] crc_reg);
        logic [31:0]          fin;
        logic [MHF_BIN_W-1:0] b;
        fin = ~crc_reg;
        for (int i = 0; i < MHF_BIN_W; i++) begin
            b[MHF_BIN_W-1-i] = fin[i];
        end
        return b;
    endfunction

    // upper bin bits pick the word
    function automatic logic [MHF_SEL_W-1:0] bin_word(input logic [MHF_BIN_W-1:0] bin);
        return bin[MHF_BIN_W-1 -: MHF_SEL_W];
    endfunction

    // lower bin bits count from the word's MSB; with a power-of-two word
    // width, (width-1) - x equals the bitwise inverse of x
    function automatic logic [MHF_POS_W-1:0] bin_bit(input logic [MHF_BIN_W-1:0] bin);
        return ~bin[MHF_POS_W-1:0];
    endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
#(
    parameter int MAC_BYTES = MHF_MAC_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [8*MAC_BYTES-1:0] mac_i,
    output logic                   busy_o,
    output bin_req_t               req_o
);

    localparam int MAC_W = 8 * MAC_BYTES;
    localparam int CNT_W = $clog2(MAC_BYTES + 1);
    localparam int LAST  = MAC_BYTES - 1;

    eng_state_e       state_q;
    logic [MAC_W-1:0] shift_q;
    logic [31:0]      crc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             group_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            shift_q <= '0;
            crc_q   <= '1;
            cnt_q   <= '0;
            group_q <= 1'b0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        state_q <= ENG_RUN;
                        shift_q <= mac_i;
                        group_q <= mac_i[MAC_W-8];
                        crc_q   <= '1;
                        cnt_q   <= '0;
                    end
                end
                ENG_RUN: begin
                    crc_q   <= crc_fold_byte(crc_q, shift_q[MAC_W-1 -: 8]);
                    shift_q <= {shift_q[MAC_W-9:0], 8'h00};
                    cnt_q   <= cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(LAST)) begin
                        state_q <= ENG_FINISH;
                    end
                end
                ENG_FINISH: state_q <= ENG_IDLE;
                default:    state_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ENG_IDLE);
    assign req_o.valid = (state_q == ENG_FINISH);
    assign req_o.group = group_q;
    assign req_o.bin   = bin_from_crc(crc_q);

    AST_FINISH_AFTER_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_FINISH) |-> ($past(state_q) == ENG_RUN && $past(cnt_q) == CNT_W'(LAST)))
        else $error("finish without six folded bytes"); // R9

    AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_RUN && cnt_q != CNT_W'(LAST) && start_i)
            |=> (state_q == ENG_RUN && cnt_q == $past(cnt_q) + CNT_W'(1) && $stable(group_q)))
        else $error("start while busy disturbed the lookup"); // R10

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int WORDS  = MHF_WORDS,
    parameter int WORD_W = MHF_WORD_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_sel,
    input  logic [WORD_W-1:0]        wr_data,
    input  bin_op_t                  op_i,
    input  logic [$clog2(WORDS)-1:0] rd_sel,
    output logic [WORD_W-1:0]        rd_data,
    input  logic [MHF_BIN_W-1:0]     look_bin,
    output logic                     look_bit
);

    localparam int SEL_W = $clog2(WORDS);
    localparam int POS_W = $clog2(WORD_W);

    logic [WORDS-1:0][WORD_W-1:0] words_q;
    logic [WORDS-1:0][WORD_W-1:0] words_d;
    logic [SEL_W-1:0]             op_sel;
    logic [POS_W-1:0]             op_pos;

    assign op_sel = bin_word(op_i.bin);
    assign op_pos = bin_bit(op_i.bin);

    // whole-word write first, bin operation on top of it
    always_comb begin
        words_d = words_q;
        if (wr_en) begin
            words_d[wr_sel] = wr_data;
        end
        if (op_i.valid) begin
            words_d[op_sel][op_pos] = op_i.set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign rd_data  = words_q[rd_sel];
    assign look_bit = words_q[bin_word(look_bin)][bin_bit(look_bin)];

    AST_TABLE_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (words_q == '0))
        else $error("table not cleared by reset"); // R1

    AST_BIN_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (op_i.valid && op_i.set) |=> words_q[$past(op_sel)][$past(op_pos)])
        else $error("bin set did not land"); // R3

    AST_BIN_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (op_i.valid && !op_i.set) |=> !words_q[$past(op_sel)][$past(op_pos)])
        else $error("bin clear did not land"); // R4

    AST_IDLE_TABLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !op_i.valid) |=> $stable(words_q))
        else $error("table changed without a command"); // R3

endmodule

// File: rtl/mhf_result_stage.sv
module mhf_result_stage
    import mhf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bin_req_t             req_i,
    input  logic                 table_bit_i,
    output logic                 done_o,
    output logic                 hit_o,
    output logic [MHF_BIN_W-1:0] bin_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            hit_o  <= 1'b0;
            bin_o  <= '0;
        end else begin
            done_o <= req_i.valid;
            if (req_i.valid) begin
                hit_o <= req_i.group & table_bit_i;
                bin_o <= req_i.bin;
            end
        end
    end

    AST_UNICAST_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && !req_i.group) |=> (done_o && !hit_o))
        else $error("unicast address reported a hit"); // R8

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done held longer than one cycle"); // R9

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_word,
    input  logic [31:0] cfg_wr_data,
    input  logic        bin_op_en,
    input  logic        bin_op_set,
    input  logic [7:0]  bin_op_bin,
    input  logic [2:0]  cfg_rd_word,
    output logic [31:0] cfg_rd_data,
    input  logic        lk_start,
    input  logic [47:0] lk_mac,
    output logic        lk_busy,
    output logic        lk_done,
    output logic        lk_hit,
    output logic [7:0]  lk_bin
);

    bin_op_t  op;
    bin_req_t req;
    logic     table_bit;

    assign op.valid = bin_op_en;
    assign op.set   = bin_op_set;
    assign op.bin   = bin_op_bin;

    mhf_crc_engine #(
        .MAC_BYTES (MHF_MAC_BYTES)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start_i (lk_start),
        .mac_i   (lk_mac),
        .busy_o  (lk_busy),
        .req_o   (req)
    );

    mhf_hash_table #(
        .WORDS  (MHF_WORDS),
        .WORD_W (MHF_WORD_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_word),
        .wr_data  (cfg_wr_data),
        .op_i     (op),
        .rd_sel   (cfg_rd_word),
        .rd_data  (cfg_rd_data),
        .look_bin (req.bin),
        .look_bit (table_bit)
    );

    mhf_result_stage u_result (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .table_bit_i (table_bit),
        .done_o      (lk_done),
        .hit_o       (lk_hit),
        .bin_o       (lk_bin)
    );

    AST_BUSY_DROPS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        lk_done |-> (!lk_busy && $past(lk_busy)))
        else $error("busy and done out of step"); // R9

endmodule

// File: tb/test_mcast_hash_filter.sv
`timescale 1ns/1ps
module test_mcast_hash_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_word = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        bin_op_en = 1'b0;
    logic        bin_op_set = 1'b0;
    logic [7:0]  bin_op_bin = '0;
    logic [2:0]  cfg_rd_word = '0;
    logic [31:0] cfg_rd_data;
    logic        lk_start = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        lk_busy, lk_done, lk_hit;
    logic [7:0]  lk_bin;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] model [8];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    mcast_hash_filter i_mcast_hash_filter (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_word(cfg_wr_word), .cfg_wr_data(cfg_wr_data),
        .bin_op_en(bin_op_en), .bin_op_set(bin_op_set), .bin_op_bin(bin_op_bin),
        .cfg_rd_word(cfg_rd_word), .cfg_rd_data(cfg_rd_data),
        .lk_start(lk_start), .lk_mac(lk_mac), .lk_busy(lk_busy),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_bin(lk_bin)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[15:0], seed[31:16]} ^ (seed >> 7);
    endfunction

    // bit-serial CRC over 48 address bits, then reverse the whole word
    function automatic logic [7:0] ref_bin(input logic [47:0] mac);
        logic [31:0] crc, fin, rev;
        logic [7:0]  d;
        logic        fb;
        crc = 32'hFFFF_FFFF;
        for (int j = 0; j < 6; j++) begin
            d = mac[47-8*j -: 8];
            for (int i = 0; i < 8; i++) begin
                fb  = crc[0] ^ d[i];
                crc = {1'b0, crc[31:1]};
                if (fb) crc = crc ^ 32'hEDB8_8320;
            end
        end
        fin = ~crc;
        for (int i = 0; i < 32; i++) rev[31-i] = fin[i];
        return rev[31:24];
    endfunction

    function automatic bit model_bit(input logic [7:0] b);
        return model[b / 32][31 - (b % 32)];
    endfunction

    task automatic word_write(input logic [2:0] w, input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_word = w; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model[w] = v;
    endtask

    task automatic bin_op(input bit s, input logic [7:0] b);
        @(negedge clk);
        bin_op_en = 1'b1; bin_op_set = s; bin_op_bin = b;
        @(negedge clk);
        bin_op_en = 1'b0;
        model[b / 32][31 - (b % 32)] = s;
    endtask

    task automatic read_check(input logic [2:0] w, input string req);
        cfg_rd_word = w;
        #0.5;
        chk(cfg_rd_data == model[w], req, cfg_rd_data, model[w]);
    endtask

    // start on edge E0; done expected after E7
    task automatic run_lookup(input logic [47:0] mac, input bit exp_hit,
                              input int poke_at, input bit intr, input logic [47:0] intr_mac);
        logic [7:0] b;
        b = ref_bin(mac);
        @(negedge clk);
        lk_start = 1'b1; lk_mac = mac;
        @(posedge clk);
        @(negedge clk);
        lk_start = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            bin_op_en = 1'b0;
            lk_start  = 1'b0;
            if (intr && k == 2) begin
                lk_start = 1'b1; lk_mac = intr_mac;
            end
            if (poke_at == k) begin
                bin_op_en = 1'b1; bin_op_set = 1'b1; bin_op_bin = b;
                model[b / 32][31 - (b % 32)] = 1'b1;
            end
            if (k == 6) chk(lk_done == 1'b0 && lk_busy == 1'b1, "R9 early done", {lk_done, lk_busy}, 2'b01);
            if (k == 7) begin
                chk(lk_done == 1'b1 && lk_busy == 1'b0, "R9 done pulse", {lk_done, lk_busy}, 2'b10);
                chk(lk_bin == b, "R6 bin number", lk_bin, b);
                chk(lk_hit == exp_hit, "R7 hit", lk_hit, exp_hit);
            end
        end
        if (intr) begin
            for (int k = 0; k < 8; k++) begin
                @(posedge clk);
                @(negedge clk);
                chk(lk_done == 1'b0, "R10 extra done", lk_done, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9: watchdog expired, actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] mac;
        logic [31:0] v;
        logic [7:0]  b;
        for (int w = 0; w < 8; w++) model[w] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({lk_done, lk_hit, lk_busy} == 3'b000, "R1 outputs", {lk_done, lk_hit, lk_busy}, 3'b000);
        for (int w = 0; w < 8; w++) read_check(3'(w), "R1 table zero");

        // R2: word writes and read-back
        for (int w = 0; w < 8; w++) word_write(3'(w), rnd());
        for (int w = 0; w < 8; w++) read_check(3'(w), "R2 word read");
        for (int w = 0; w < 8; w++) word_write(3'(w), 32'h0);

        // R3: set every bin from an empty table
        for (int i = 0; i < 256; i++) begin
            bin_op(1'b1, 8'(i));
            read_check(3'(i / 32), "R3 bin set");
        end
        for (int w = 0; w < 8; w++) read_check(3'(w), "R3 all ones");
        chk(model[0][31] && model[7][0], "R3 bin ends", {model[0][31], model[7][0]}, 2'b11);

        // R4: clear every bin in a scattered order
        for (int i = 0; i < 256; i++) begin
            b = 8'(i * 37 + 11);
            bin_op(1'b0, b);
            read_check(3'(b / 32), "R4 bin clear");
        end
        for (int w = 0; w < 8; w++) read_check(3'(w), "R4 all zero");

        // R5: word write and bin op in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_word = 3'd2; cfg_wr_data = 32'h0F0F_0000;
        bin_op_en = 1'b1; bin_op_set = 1'b1; bin_op_bin = 8'd95;
        @(negedge clk);
        cfg_wr_en = 1'b0; bin_op_en = 1'b0;
        model[2] = 32'h0F0F_0001;
        read_check(3'd2, "R5 write then set");
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_word = 3'd2; cfg_wr_data = 32'hFFFF_FFFF;
        bin_op_en = 1'b1; bin_op_set = 1'b0; bin_op_bin = 8'd64;
        @(negedge clk);
        cfg_wr_en = 1'b0; bin_op_en = 1'b0;
        model[2] = 32'h7FFF_FFFF;
        read_check(3'd2, "R5 write then clear");

        // R6 R7: lookups against two random tables
        for (int t = 0; t < 2; t++) begin
            for (int w = 0; w < 8; w++) word_write(3'(w), rnd());
            for (int n = 0; n < 48; n++) begin
                mac = {rnd()[15:0], rnd()};
                mac[40] = 1'b1;
                run_lookup(mac, model_bit(ref_bin(mac)), 0, 1'b0, 48'h0);
            end
        end

        // R8: unicast never hits, even on a full table
        for (int w = 0; w < 8; w++) word_write(3'(w), 32'hFFFF_FFFF);
        for (int n = 0; n < 16; n++) begin
            mac = {rnd()[15:0], rnd()};
            mac[40] = 1'b0;
            run_lookup(mac, 1'b0, 0, 1'b0, 48'h0);
        end

        // R10: a second start while busy is ignored
        for (int w = 0; w < 8; w++) word_write(3'(w), rnd());
        run_lookup(48'h0100_5E00_0001, model_bit(ref_bin(48'h0100_5E00_0001)), 0,
                   1'b1, 48'h3333_0000_00FB);

        // R11: a set landing with the result edge is not seen until the next lookup
        for (int w = 0; w < 8; w++) word_write(3'(w), 32'h0);
        mac = 48'h0100_5E7F_FFFA;
        run_lookup(mac, 1'b0, 6, 1'b0, 48'h0);
        @(negedge clk);
        bin_op_en = 1'b0;
        run_lookup(mac, 1'b1, 0, 1'b0, 48'h0);
        v = model[ref_bin(mac) / 32];
        read_check(3'(ref_bin(mac) / 32), "R11 bin stored");
        chk(v != 32'h0, "R11 model", v, 32'h1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule